// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block connects a clocked host to an external asynchronous static RAM of 512K bytes. The RAM has active-low chip select, output enable and write enable pins and a single bidirectional 8-bit data bus. The host issues one request at a time on a request/acknowledge port. That request carries a 19-bit address, a direction flag and write data. The controller answers with a one-cycle acknowledge. On a read, the captured byte is returned with that acknowledge.

The memory needs no clock, so every analog minimum from its timing table is a parameter in nanoseconds. Each one is rounded up to whole clock cycles. The controller then orders the strobe edges so that a write pulse never opens before the address is stable. It also ensures the shared bus is never driven by the controller and the memory at the same time. Writes are done with output enable held high. The bus pins are split into an output value, an output enable and an input value. The pad tri-state buffer is placed one level up.

Top module: `asram_port`

## Requirements
- R1: While reset is asserted and after it is released, chip select, output enable and write enable are all high, the data drivers are off and ack is low.
- R2: Write enable falls only after chip select has been low, with output enable high and data drivers off, for ceil(tOHZ/clk) cycles. Write enable and output enable are never low together.
- R3: Write enable stays low for ceil(max(tWP, tCW, tAW, tDW)/clk) cycles. The controller drives constant write data on the bus for the whole of that window.
- R4: After write enable and chip select rise together, the data drivers stay on for HOLD_CYC cycles and then turn off.
- R5: A read holds chip select and output enable low with write enable high for ceil(tAA/clk)+1 cycles. The byte on the bus is captured at the end of that window, and rdata carries it while ack is high.
- R6: After output enable rises, the data drivers stay off for at least ceil(tOHZ/clk) cycles, so they never overlap the memory's own drive.
- R7: ack is a single-cycle pulse. It rises OHZ+WIN+HOLD+1 cycles after a write is accepted and AA+1+OHZ+1 cycles after a read is accepted, where each term is the rounded cycle count named in R2 to R5.
- R8: A request is taken only in idle. Changes to req, addr or wdata during a cycle have no effect on the memory address pins or on the memory contents.
- R9: The whole 19-bit address range reaches the pins, including address 0x7FFFF. Data written at any address reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Host request, sampled only in idle |
| we_req | input | 1 | 1 = write, 0 = read |
| addr | input | 19 | Host byte address |
| wdata | input | 8 | Host write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with ack after a read |
| mem_addr | output | 19 | Memory address pins |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_o | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Controller drives the data bus when high |
| mem_dq_i | input | 8 | Value read from the data bus |

## Verification
The bound checker enforces the strobe rules on every cycle:
- write enable and output enable are never low together;
- output enable is never low outside a selected read;
- write data and address stay frozen while the strobes are active;
- the controller drivers stay off for the turn-around gap after output enable rises;
- the acknowledge lasts one cycle.

Exact phase lengths, latency, the moment of read sampling and what actually lands in memory can only be shown by the bench. It uses a memory model whose read data turns valid only tAA after selection. It also reads back locations that an ignored request might have corrupted.

// File: rtl/asram_pkg.sv
// Shared types and helpers for the static RAM port controller.
// Assumes all timing values are non-negative nanosecond integers.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WSETUP  = 3'd1,
        ST_WPULSE  = 3'd2,
        ST_WHOLD   = 3'd3,
        ST_RACCESS = 3'd4,
        ST_RREL    = 3'd5
    } phase_e;

    // Rounds a nanosecond minimum up to whole cycles, never below one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
// Phase down-counter. A load of N makes the phase last N cycles, with
// 'last' high in its final cycle. Assumes N >= 1.
module asram_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    // Count down to zero; reload on phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val - 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
// Phase sequencer. Steps idle -> setup -> pulse -> hold for a write and
// idle -> access -> release for a read, and loads the timer with each
// phase length. Assumes every phase count is at least one.
module asram_seq
    import asram_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int OHZ_CYC = 4,
    parameter int WIN_CYC = 8,
    parameter int HLD_CYC = 1,
    parameter int AA_CYC  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we_req,
    input  logic             last,
    output phase_e           state_q,
    output phase_e           state_d,
    output logic             accept,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);
    localparam logic [CNT_W-1:0] V_OHZ = CNT_W'(OHZ_CYC);
    localparam logic [CNT_W-1:0] V_WIN = CNT_W'(WIN_CYC);
    localparam logic [CNT_W-1:0] V_HLD = CNT_W'(HLD_CYC);
    localparam logic [CNT_W-1:0] V_AA  = CNT_W'(AA_CYC);

    // Next phase and the timer load that goes with entering it.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = V_OHZ;
        accept   = 1'b0;
        case (state_q)
            ST_IDLE: if (req) begin
                accept   = 1'b1;
                tmr_load = 1'b1;
                if (we_req) begin
                    state_d = ST_WSETUP;
                    tmr_val = V_OHZ;
                end else begin
                    state_d = ST_RACCESS;
                    tmr_val = V_AA;
                end
            end
            ST_WSETUP: if (last) begin
                state_d  = ST_WPULSE;
                tmr_load = 1'b1;
                tmr_val  = V_WIN;
            end
            ST_WPULSE: if (last) begin
                state_d  = ST_WHOLD;
                tmr_load = 1'b1;
                tmr_val  = V_HLD;
            end
            ST_WHOLD:  if (last) state_d = ST_IDLE;
            ST_RACCESS: if (last) begin
                state_d  = ST_RREL;
                tmr_load = 1'b1;
                tmr_val  = V_OHZ;
            end
            ST_RREL:   if (last) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/asram_pins.sv
// Pin and host datapath. Registers strobes decoded from the next phase,
// latches address and write data on accept, captures read data at the
// end of the access window and pulses ack on return to idle.
module asram_pins
    import asram_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            state_q,
    input  phase_e            state_d,
    input  logic              accept,
    input  logic              last,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe
);
    // Glitch-free strobes: registered from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_cs_n  <= !(state_d == ST_WSETUP || state_d == ST_WPULSE ||
                           state_d == ST_RACCESS);
            mem_oe_n  <= !(state_d == ST_RACCESS);
            mem_we_n  <= !(state_d == ST_WPULSE);
            mem_dq_oe <= (state_d == ST_WPULSE || state_d == ST_WHOLD);
        end
    end

    // Latch address and write data once per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (accept) begin
            mem_addr <= addr;
            mem_dq_o <= wdata;
        end
    end

    // Capture the read byte and produce the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            ack   <= 1'b0;
        end else begin
            if (state_q == ST_RACCESS && last)
                rdata <= mem_dq_i;
            ack <= (state_q == ST_WHOLD || state_q == ST_RREL) && last;
        end
    end
endmodule

// File: rtl/asram_port.sv
// Top of the static RAM port controller. Converts nanosecond minimums
// into cycle counts and connects sequencer, timer and pin datapath.
// Assumes CLK_NS is the true clock period and one request in flight.
module asram_port
    import asram_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_AA_NS   = 85,
    parameter int T_WP_NS   = 55,
    parameter int T_CW_NS   = 75,
    parameter int T_AW_NS   = 75,
    parameter int T_DW_NS   = 35,
    parameter int T_OHZ_NS  = 35,
    parameter int HOLD_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int WIN_NS  = imax(imax(T_WP_NS, T_CW_NS), imax(T_AW_NS, T_DW_NS));
    localparam int OHZ_CYC = ns2cyc(T_OHZ_NS, CLK_NS);
    localparam int WIN_CYC = ns2cyc(WIN_NS, CLK_NS);
    localparam int HLD_CYC = (HOLD_CYC < 1) ? 1 : HOLD_CYC;
    localparam int AA_CYC  = ns2cyc(T_AA_NS, CLK_NS) + 1;
    localparam int MAX_CYC = imax(imax(OHZ_CYC, WIN_CYC), imax(HLD_CYC, AA_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    phase_e           state_q, state_d;
    logic             accept, tmr_load, last;
    logic [CNT_W-1:0] tmr_val;

    asram_seq #(
        .CNT_W(CNT_W), .OHZ_CYC(OHZ_CYC), .WIN_CYC(WIN_CYC),
        .HLD_CYC(HLD_CYC), .AA_CYC(AA_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .we_req(we_req), .last(last),
        .state_q(state_q), .state_d(state_d), .accept(accept),
        .tmr_load(tmr_load), .tmr_val(tmr_val)
    );

    asram_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .last(last)
    );

    asram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .state_q(state_q), .state_d(state_d),
        .accept(accept), .last(last), .addr(addr), .wdata(wdata),
        .mem_dq_i(mem_dq_i), .ack(ack), .rdata(rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
    );
endmodule

// File: rtl/asram_port_chk.sv
// Protocol checker for asram_port, bound to every instance. Observes
// only the host and memory pins, plus a bus turn-around counter.
module asram_port_chk #(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 8,
    parameter int OHZ_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);
    logic [7:0] gap_q;

    // Cycles since output enable was last low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)             gap_q <= 8'hFF;
        else if (!mem_oe_n)     gap_q <= 8'h00;
        else if (gap_q != 8'hFF) gap_q <= gap_q + 8'h01;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !ack));

    // R2
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R2
    we_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(!mem_cs_n) && $stable(mem_addr)));

    // R3
    wdata_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> (mem_dq_oe && $stable(mem_dq_o)));

    // R5
    oe_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n && !mem_dq_oe));

    // R6
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (gap_q >= 8'(OHZ_CYC)));

    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R8
    addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
endmodule

bind asram_port asram_port_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OHZ_CYC(OHZ_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
);

// File: tb/asram_port_test.sv
// Directed bench for asram_port with a behavioural asynchronous RAM.
module asram_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int OHZ  = (35 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int WIN  = (75 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int HOLD = 1;
    localparam int AAV  = (85 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int AAC  = AAV + 1;
    localparam int WR_LAT = OHZ + WIN + HOLD + 1;
    localparam int RD_LAT = AAC + OHZ + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we_req = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ack;
    logic [7:0]  rdata;
    logic [18:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_o, mem_dq_i;

    int n_tests = 0, n_fail = 0;
    int contention = 0, overlap = 0, wr_undriven = 0, setup_drv = 0;
    int acc_cnt = 0, drv_tail = 0, setup_run = 0, last_setup = 0;
    int we_len = 0, last_we_len = 0, hold_len = 0;
    bit wact = 0, htrack = 0, done = 0;
    logic [18:0] waddr;
    logic [7:0]  wbuf;
    logic [7:0]  mem [int unsigned];

    asram_port uut (
        .clk(clk), .rst_n(rst_n), .req(req), .we_req(we_req), .addr(addr),
        .wdata(wdata), .ack(ack), .rdata(rdata), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] rd_mem(input logic [18:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
    endfunction

    wire rd_active = !mem_cs_n && !mem_oe_n && mem_we_n;
    assign mem_dq_i = (rd_active && acc_cnt >= AAV) ? rd_mem(mem_addr) : 8'hEE;

    // Memory model, evaluated away from the active edge.
    always @(negedge clk) begin
        if (rd_active) begin acc_cnt++; drv_tail = OHZ; end
        else begin acc_cnt = 0; if (drv_tail > 0) drv_tail--; end
        if (mem_dq_oe && (rd_active || drv_tail > 0)) contention++;
        if (!mem_we_n && !mem_oe_n) overlap++;
        if (mem_cs_n) setup_run = 0;
        else if (mem_we_n && mem_oe_n) begin
            setup_run++;
            if (mem_dq_oe) setup_drv++;
        end
        if (!mem_cs_n && !mem_we_n) begin
            if (!wact) begin last_setup = setup_run; we_len = 0; end
            if (!mem_dq_oe) wr_undriven++;
            wbuf = mem_dq_o; waddr = mem_addr; wact = 1; we_len++;
        end else if (wact) begin
            mem[int'(waddr)] = wbuf; wact = 0; last_we_len = we_len;
            htrack = 1; hold_len = mem_dq_oe ? 1 : 0;
            if (!mem_dq_oe) htrack = 0;
        end else if (htrack) begin
            if (mem_dq_oe) hold_len++; else htrack = 0;
        end
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !ack, "R1 in reset",
              {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, ack}, 5'b11100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !ack, "R1 after reset",
              {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, ack}, 5'b11100);
    endtask

    task automatic t_write(input logic [18:0] a, input logic [7:0] d);
        int n = 0;
        req = 1'b1; we_req = 1'b1; addr = a; wdata = d;
        do begin @(negedge clk); req = 1'b0; n++; end while (!ack && n < 100);
        check(n == WR_LAT, "R7 write latency", n, WR_LAT);
        check(last_setup == OHZ, "R2 setup cycles", last_setup, OHZ);
        check(last_we_len == WIN, "R3 write window", last_we_len, WIN);
        check(hold_len == HOLD, "R4 hold cycles", hold_len, HOLD);
        check(rd_mem(a) == d, "R9 stored byte", rd_mem(a), d);
        @(negedge clk);
        check(!ack, "R7 ack width", ack, 0);
    endtask

    task automatic t_read(input logic [18:0] a, input logic [7:0] exp);
        int n = 0;
        req = 1'b1; we_req = 1'b0; addr = a;
        do begin @(negedge clk); req = 1'b0; n++; end while (!ack && n < 100);
        check(n == RD_LAT, "R7 read latency", n, RD_LAT);
        check(rdata == exp, "R5 rdata with ack", rdata, exp);
        @(negedge clk);
        check(!ack, "R7 ack width", ack, 0);
    endtask

    task automatic t_patterns();
        t_write(19'h00000, 8'hA5);
        t_write(19'h7FFFF, 8'h5A);
        t_write(19'h2AAAA, 8'hFF);
        t_read(19'h00000, 8'hA5);
        t_read(19'h7FFFF, 8'h5A);   // R9 top address
        check(mem_addr == 19'h7FFFF, "R9 address pins", mem_addr, 19'h7FFFF);
        t_read(19'h2AAAA, 8'hFF);
        t_write(19'h2AAAA, 8'h00);  // read then write back to back
        t_read(19'h2AAAA, 8'h00);
    endtask

    task automatic t_busy_ignore();
        int n = 0;
        bit moved = 0;
        req = 1'b1; we_req = 1'b1; addr = 19'h01234; wdata = 8'h3C;
        do begin
            @(negedge clk); n++;
            req = (n % 3 == 1);
            addr = 19'h05555; wdata = 8'hC3;
            if (!mem_cs_n && mem_addr != 19'h01234) moved = 1;
            if (n == WR_LAT - 2) req = 1'b0;
        end while (!ack && n < 100);
        req = 1'b0;
        check(!moved, "R8 address pins held", moved, 0);
        check(n == WR_LAT, "R8 latency unchanged", n, WR_LAT);
        repeat (3) @(negedge clk);
        check(mem_cs_n, "R8 no extra request", mem_cs_n, 1);
        t_read(19'h01234, 8'h3C);
        t_read(19'h05555, 8'h00);   // R8 untouched location
    endtask

    task automatic t_bus_summary();
        check(contention == 0, "R6 bus contention", contention, 0);
        check(setup_drv == 0, "R2 drivers off in setup", setup_drv, 0);
        check(overlap == 0, "R2 we/oe overlap", overlap, 0);
        check(wr_undriven == 0, "R3 data driven in window", wr_undriven, 0);
    endtask

    initial begin
        t_reset();
        t_patterns();
        t_busy_ignore();
        t_bus_summary();
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule